// File: doc/BRIEF.md
# Preload Channel Status Bank

This block keeps one 32-bit status word for each channel of a preload engine and answers register accesses aimed at whichever channel an external select input names. Engine-side events (start, complete, error) update the word of the channel they carry. An error event also brings a 7-bit fault code that is stored in the word.

Each register request carries the requester's security state (Secure or Nonsecure), its privilege (privileged or User), the user-access bits for every channel and a global Nonsecure-enable bit. One cycle after the request the block returns the status word or raises an undefined-instruction indication. The register is read-only, so every write faults.

Top module: `preload_status_file`

## Requirements
- R1: After reset every channel reads as all zeros: status 00 (idle) and an empty error field. No response is presented while no request has been made.
- R2: A returned word has status in bits [1:0] (00 idle, 10 running, 11 complete or error), the error field in bits [8:2], and zeros in bits [31:9]. The status value 01 is never produced.
- R3: A start event sets the channel's status to 10 and clears its whole error field.
- R4: A complete event sets the channel's status to 11 and clears its whole error field, so bit [8] reads 0.
- R5: An error event sets the status to 11 and stores the supplied fault code in bits [8:2], with bit [8] forced to 1. The other code bits are kept as supplied, including bit [7] (0 for a decode response, 1 for a slave response). This covers codes such as 1x01100, 1011100, 1x10110 and 1001111.
- R6: When several events name the same channel in one cycle, error wins over complete, and complete wins over start. An event only changes the channel it names. An event that names a channel beyond the channel count changes nothing.
- R7: Every write request raises the undefined indication, whatever the state and enable bits.
- R8: A read returns data in these cases: Secure privileged, always; Nonsecure privileged, when Nonsecure-enable is 1; Secure User, when the selected channel's user-access bit is 1; Nonsecure User, when both of those bits are 1. Every other read raises the undefined indication.
- R9: A response that raises the undefined indication carries zero data. A request whose select value is at or beyond the channel count raises the undefined indication.
- R10: The response appears in the cycle after the request. It reflects the channel state from before any event applied in the request cycle. Requests may come back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evStart | input | 1 | Start event strobe |
| evStartCh | input | CH_SEL_W | Channel index of the start event |
| evDone | input | 1 | Complete event strobe |
| evDoneCh | input | CH_SEL_W | Channel index of the complete event |
| evErr | input | 1 | Error event strobe |
| evErrCh | input | CH_SEL_W | Channel index of the error event |
| evErrCode | input | 7 | Fault code carried by the error event |
| reqValid | input | 1 | Register request strobe |
| reqWrite | input | 1 | 1 = write request, 0 = read request |
| reqSecure | input | 1 | 1 = Secure state, 0 = Nonsecure |
| reqPriv | input | 1 | 1 = privileged, 0 = User |
| chSel | input | CH_SEL_W | Selected channel |
| userEn | input | NUM_CH | Per-channel user-access bits |
| nsEnable | input | 1 | Global Nonsecure-enable bit |
| rspValid | output | 1 | Response strobe, one cycle after the request |
| rspUndef | output | 1 | Undefined-instruction indication |
| rspData | output | 32 | Status word, zero when undefined |

## Verification
A corrupted channel word shows up only on the next granted read of that channel. For that reason the bench reads each touched channel in the cycle after the events and compares all 32 bits, so a wrong status, code bit or stray reserved bit appears one cycle after the request. A decode fault in the permission logic shows as a wrong undefined flag on the very next response, and the bench sweeps all sixteen combinations of state, privilege and the two enable bits. Priority or range mistakes in event decode show as a neighbouring or winning channel holding the wrong word on the following reads.

// File: rtl/pstat_pkg.sv
package pstat_pkg;

  localparam int WORD_W = 32;
  localparam int CODE_W = 7;
  localparam int STAT_W = 2;

  localparam logic [STAT_W-1:0] ST_IDLE = 2'b00;
  localparam logic [STAT_W-1:0] ST_RUN  = 2'b10;
  localparam logic [STAT_W-1:0] ST_END  = 2'b11;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_START = 2'd1,
    EV_DONE  = 2'd2,
    EV_ERR   = 2'd3
  } evOp_t;

  // strobes from control to datapath for the register side
  typedef struct packed {
    logic respond;
    logic grant;
  } accStrobe_t;

endpackage

// File: rtl/pstat_ctrl.sv
module pstat_ctrl
  import pstat_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int CH_SEL_W = 3,
  parameter int IDX_W    = 2
) (
  input  logic                evStart,
  input  logic [CH_SEL_W-1:0] evStartCh,
  input  logic                evDone,
  input  logic [CH_SEL_W-1:0] evDoneCh,
  input  logic                evErr,
  input  logic [CH_SEL_W-1:0] evErrCh,
  input  logic [CODE_W-1:0]   evErrCode,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic                reqSecure,
  input  logic                reqPriv,
  input  logic [CH_SEL_W-1:0] chSel,
  input  logic [NUM_CH-1:0]   userEn,
  input  logic                nsEnable,
  output accStrobe_t          acc,
  output logic [IDX_W-1:0]    rdIdx,
  output evOp_t               evOp [NUM_CH],
  output logic [CODE_W-1:0]   loadCode
);

  logic selInRange;
  logic userBit;
  logic stateOk;
  logic readOk;

  // register-side permission decode
  always_comb begin
    selInRange = (int'(chSel) < NUM_CH);
    rdIdx      = chSel[IDX_W-1:0];
    userBit    = selInRange ? userEn[rdIdx] : 1'b0;
    stateOk    = reqSecure | nsEnable;
    readOk     = reqPriv ? stateOk : (userBit & stateOk);
    acc.respond = reqValid;
    acc.grant   = reqValid & ~reqWrite & selInRange & readOk;
  end

  // fault code always marks the error-present bit
  assign loadCode = {1'b1, evErrCode[CODE_W-2:0]};

  // engine-side event decode, later assignment wins: error > done > start
  for (genvar i = 0; i < NUM_CH; i++) begin : g_evDec
    always_comb begin
      evOp[i] = EV_NONE;
      if (evStart && int'(evStartCh) == i) evOp[i] = EV_START;
      if (evDone  && int'(evDoneCh)  == i) evOp[i] = EV_DONE;
      if (evErr   && int'(evErrCh)   == i) evOp[i] = EV_ERR;
    end
  end

endmodule

// File: rtl/pstat_datapath.sv
module pstat_datapath
  import pstat_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  accStrobe_t        acc,
  input  logic [IDX_W-1:0]  rdIdx,
  input  evOp_t             evOp [NUM_CH],
  input  logic [CODE_W-1:0] loadCode,
  output logic              rspValid,
  output logic              rspUndef,
  output logic [WORD_W-1:0] rspData
);

  localparam int PAD_W = WORD_W - CODE_W - STAT_W;

  logic [STAT_W-1:0] statQ [NUM_CH];
  logic [CODE_W-1:0] codeQ [NUM_CH];
  logic [WORD_W-1:0] rdWord;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        statQ[i] <= ST_IDLE;
        codeQ[i] <= '0;
      end else begin
        case (evOp[i])
          EV_START: begin statQ[i] <= ST_RUN; codeQ[i] <= '0;       end
          EV_DONE:  begin statQ[i] <= ST_END; codeQ[i] <= '0;       end
          EV_ERR:   begin statQ[i] <= ST_END; codeQ[i] <= loadCode; end
          default:  ;
        endcase
      end
    end

    a_r3_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
      evOp[i] == EV_START |=> statQ[i] == ST_RUN && codeQ[i] == '0);
    a_r4_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
      evOp[i] == EV_DONE |=> statQ[i] == ST_END && codeQ[i] == '0);
    a_r5_err_flagged: assert property (@(posedge clk) disable iff (!rst_n)
      evOp[i] == EV_ERR |=> statQ[i] == ST_END && codeQ[i][CODE_W-1]);
    a_r6_quiet_holds: assert property (@(posedge clk) disable iff (!rst_n)
      evOp[i] == EV_NONE |=> $stable(statQ[i]) && $stable(codeQ[i]));
    a_r2_no_reserved_status: assert property (@(posedge clk) disable iff (!rst_n)
      statQ[i] != 2'b01);
  end

  always_comb begin
    rdWord = '0;
    if (acc.grant) rdWord = {{PAD_W{1'b0}}, codeQ[rdIdx], statQ[rdIdx]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rspValid <= 1'b0;
      rspUndef <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= acc.respond;
      rspUndef <= acc.respond & ~acc.grant;
      rspData  <= rdWord;
    end
  end

endmodule

// File: rtl/preload_status_file.sv
module preload_status_file
  import pstat_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int CH_SEL_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                evStart,
  input  logic [CH_SEL_W-1:0] evStartCh,
  input  logic                evDone,
  input  logic [CH_SEL_W-1:0] evDoneCh,
  input  logic                evErr,
  input  logic [CH_SEL_W-1:0] evErrCh,
  input  logic [6:0]          evErrCode,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic                reqSecure,
  input  logic                reqPriv,
  input  logic [CH_SEL_W-1:0] chSel,
  input  logic [NUM_CH-1:0]   userEn,
  input  logic                nsEnable,
  output logic                rspValid,
  output logic                rspUndef,
  output logic [31:0]         rspData
);

  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  accStrobe_t        acc;
  logic [IDX_W-1:0]  rdIdx;
  evOp_t             evOp [NUM_CH];
  logic [CODE_W-1:0] loadCode;

  pstat_ctrl #(.NUM_CH(NUM_CH), .CH_SEL_W(CH_SEL_W), .IDX_W(IDX_W)) u_ctrl (
    .evStart(evStart), .evStartCh(evStartCh),
    .evDone(evDone), .evDoneCh(evDoneCh),
    .evErr(evErr), .evErrCh(evErrCh), .evErrCode(evErrCode),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqSecure(reqSecure),
    .reqPriv(reqPriv), .chSel(chSel), .userEn(userEn), .nsEnable(nsEnable),
    .acc(acc), .rdIdx(rdIdx), .evOp(evOp), .loadCode(loadCode)
  );

  pstat_datapath #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .acc(acc), .rdIdx(rdIdx), .evOp(evOp),
    .loadCode(loadCode), .rspValid(rspValid), .rspUndef(rspUndef),
    .rspData(rspData)
  );

  a_r10_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> rspValid);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !rspValid);
  a_r7_write_undef: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && reqWrite |=> rspUndef);
  a_r9_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rspUndef |-> rspData == 32'd0);
  a_r9_range_undef: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && int'(chSel) >= NUM_CH |=> rspUndef);
  a_r8_secure_priv: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && !reqWrite && reqSecure && reqPriv && int'(chSel) < NUM_CH
    |=> !rspUndef);
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |-> rspData[31:9] == '0);

endmodule

// File: tb/preload_status_file_bench.sv
module preload_status_file_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH     = 4;
  localparam int CH_SEL_W   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evStart = 0, evDone = 0, evErr = 0;
  logic [CH_SEL_W-1:0] evStartCh = '0, evDoneCh = '0, evErrCh = '0;
  logic [6:0] evErrCode = '0;
  logic reqValid = 0, reqWrite = 0, reqSecure = 0, reqPriv = 0, nsEnable = 0;
  logic [CH_SEL_W-1:0] chSel = '0;
  logic [NUM_CH-1:0] userEn = '0;
  logic rspValid, rspUndef;
  logic [31:0] rspData;

  always #(CLK_PERIOD/2) clk = ~clk;

  preload_status_file #(.NUM_CH(NUM_CH), .CH_SEL_W(CH_SEL_W)) u_preload_status_file (
    .clk(clk), .rst_n(rst_n),
    .evStart(evStart), .evStartCh(evStartCh), .evDone(evDone), .evDoneCh(evDoneCh),
    .evErr(evErr), .evErrCh(evErrCh), .evErrCode(evErrCode),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqSecure(reqSecure),
    .reqPriv(reqPriv), .chSel(chSel), .userEn(userEn), .nsEnable(nsEnable),
    .rspValid(rspValid), .rspUndef(rspUndef), .rspData(rspData)
  );

  typedef struct {
    logic        undef;
    logic [31:0] data;
    string       tag;
  } exp_t;

  exp_t sbq[$];
  logic [31:0] mdl [NUM_CH];
  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input logic [32:0] act,
                       input logic [32:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual undef/data=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bench model: update from the events driven in the cycle ending now
  task automatic cyc();
    @(posedge clk);
    for (int c = 0; c < NUM_CH; c++) begin
      if (evErr && int'(evErrCh) == c)
        mdl[c] = {23'd0, 1'b1, evErrCode[5:0], 2'b11};
      else if (evDone && int'(evDoneCh) == c)
        mdl[c] = 32'h3;
      else if (evStart && int'(evStartCh) == c)
        mdl[c] = 32'h2;
    end
    #1;
    evStart = 0; evDone = 0; evErr = 0; reqValid = 0; reqWrite = 0;
  endtask

  // driver: one request this cycle, expected result pushed to the scoreboard
  task automatic rd(input bit wr, input bit sec, input bit priv, input int sel,
                    input logic [NUM_CH-1:0] ue, input bit ns, input string tag);
    exp_t e;
    bit ok;
    reqValid = 1; reqWrite = wr; reqSecure = sec; reqPriv = priv;
    chSel = sel[CH_SEL_W-1:0]; userEn = ue; nsEnable = ns;
    if (wr || sel >= NUM_CH) ok = 0;
    else if (sec && priv)    ok = 1;
    else if (!sec && priv)   ok = ns;
    else if (sec && !priv)   ok = ue[sel];
    else                     ok = ue[sel] && ns;
    e.undef = !ok;
    e.data  = ok ? mdl[sel] : 32'd0;
    e.tag   = tag;
    sbq.push_back(e);
  endtask

  task automatic ev(input int kind, input int ch, input logic [6:0] code);
    case (kind)
      0: begin evStart = 1; evStartCh = ch[CH_SEL_W-1:0]; end
      1: begin evDone  = 1; evDoneCh  = ch[CH_SEL_W-1:0]; end
      default: begin evErr = 1; evErrCh = ch[CH_SEL_W-1:0]; evErrCode = code; end
    endcase
  endtask

  task automatic rdOk(input int sel, input string tag);
    cyc(); rd(0, 1, 1, sel, '0, 0, tag);
  endtask

  // monitor: pop and compare each response away from the clock edge
  always @(negedge clk) begin
    if (rst_n && rspValid) begin
      if (sbq.size() == 0) begin
        check(0, "R10 unexpected response", {rspUndef, rspData}, 33'd0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check(rspUndef === e.undef && rspData === e.data, e.tag,
              {rspUndef, rspData}, {e.undef, e.data});
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual=running expected=done");
    summary();
  end

  initial begin
    for (int c = 0; c < NUM_CH; c++) mdl[c] = 32'd0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(rspValid === 1'b0, "R1 no response after reset", {32'd0, rspValid}, 33'd0);

    // R1: all channels idle
    for (int c = 0; c < NUM_CH; c++) rdOk(c, "R1 reset word");

    // R3 start
    cyc(); ev(0, 0, '0);
    rdOk(0, "R3 start running");
    // R5 errors: decode response and slave response, bit 8 forced
    cyc(); ev(2, 1, 7'b0001100);
    rdOk(1, "R5 error decode code forced bit8");
    cyc(); ev(2, 2, 7'b1101110);
    rdOk(2, "R5 error slave code");
    cyc(); ev(2, 3, 7'b1001111);
    rdOk(3, "R5 permission fault page");
    rdOk(1, "R2 layout error word");
    // R4 complete
    cyc(); ev(1, 0, '0);
    rdOk(0, "R4 complete clears code");
    cyc(); ev(1, 2, '0);
    rdOk(2, "R4 complete after error");
    // R3 start clears prior error
    cyc(); ev(0, 1, '0);
    rdOk(1, "R3 start clears code");

    // R6 priority on one channel and independence
    cyc(); ev(0, 3, '0); ev(1, 3, '0); ev(2, 3, 7'b1011000);
    rdOk(3, "R6 error beats done and start");
    cyc(); ev(0, 0, '0); ev(1, 0, '0);
    rdOk(0, "R6 done beats start");
    cyc(); ev(0, 5, '0); ev(1, 6, '0); ev(2, 7, 7'b1011100);
    for (int c = 0; c < NUM_CH; c++) rdOk(c, "R6 out-of-range event ignored");

    // R7 writes fault in every mode
    for (int m = 0; m < 16; m++) begin
      cyc(); rd(1, m[0], m[1], 1, {NUM_CH{m[2]}}, m[3], "R7 write undefined");
    end

    // R8 permission sweep on channel 3, user bit only on channel 3 or elsewhere
    for (int m = 0; m < 16; m++) begin
      cyc(); rd(0, m[0], m[1], 3, m[2] ? 4'b1000 : 4'b0111, m[3], "R8 permission");
    end

    // R9 out-of-range select
    for (int s = NUM_CH; s < 8; s++) begin
      cyc(); rd(0, 1, 1, s, '1, 1, "R9 select out of range");
    end

    // R10 read in the same cycle as an event sees the old word
    cyc(); rd(0, 1, 1, 2, '0, 0, "R10 old value in event cycle"); ev(0, 2, '0);
    rdOk(2, "R10 new value next request");
    // R10 back to back reads across channels
    cyc(); rd(0, 1, 1, 0, '0, 0, "R10 back to back");
    cyc(); rd(0, 0, 0, 1, 4'b0010, 1, "R10 back to back");
    cyc(); rd(0, 0, 1, 2, '0, 0, "R10 back to back");
    cyc(); rd(0, 1, 1, 3, '0, 0, "R10 back to back");
    cyc();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(sbq.size() == 0, "R10 all responses seen", {1'b0, 32'(sbq.size())}, 33'd0);
    summary();
  end

endmodule